// File: doc/BRIEF.md
# Byte-Coded Stack Machine Core

This core runs a compact machine in which every instruction is a single byte. It holds four 16-bit registers: an accumulator A, a base B, an index I and the program counter P. It also holds a 16-entry circular stack whose pointer software cannot see. Each cycle it reads the byte at P through an asynchronous fetch port. It decodes the low six bits and retires the instruction in that same cycle. The exception is a label search, which waits on an external helper.

Loads and stores go through a data port that is always addressed by I and is big-endian for word accesses. Allocation and division requests are handed to an outside unit as single-cycle pulses. A zero-test prefix suppresses the instruction that follows it whenever A is not zero. Opcodes that are not defined raise a one-cycle error pulse and change nothing except P.

Top module: `smc_core`

## Requirements
- R1: After reset, P, A, B, I, every stack entry and the stack pointer are zero, so `fetch_addr_o` is 0. A store executed first writes 0 to address 0.
- R2: Bits 7:6 of a fetched byte have no effect on execution. 0xC2 behaves as opcode 2 and 0x8D behaves as opcode 13.
- R3: Opcodes 0 and 1 change no register. Opcode 2 adds one to A, 3 subtracts one from A and 4 shifts A left by one bit, all modulo 2^16.
- R4: A byte 01 d1 d0 s1 s0 (opcodes 16–31) sets register d to s XOR d. The register codes are A=0, B=1, I=2 and P=3. When d is P, the next fetch comes from the result. A source of P reads the address of the XOR byte itself.
- R5: Opcodes 32–35 push the register coded in bits 1:0, and opcodes 36–39 pop into it. A push advances the pointer and then writes; a pop reads and then retreats. The 16 entries wrap in both directions without any fault. After 17 pushes of 1..17, two pops return 17 and then 16.
- R6: Opcode 7 with A nonzero discards the next instruction. That instruction produces no store, no request and no error pulse, and P still advances past it. When A is zero, the next instruction runs normally.
- R7: Opcodes 12–15 address the data port with I. Opcode 12 loads `{0, dmem_rdata_i[15:8]}` into A. Opcode 14 loads `dmem_rdata_i` into A, where bits 15:8 hold the byte at I. Opcode 13 writes A[7:0] on `dmem_wdata_o[15:8]` with `dmem_wide_o`=0. Opcode 15 writes A on `dmem_wdata_o` with `dmem_wide_o`=1.
- R8: Opcodes 5, 6 and 40–63 pulse `illegal_o` for one cycle and leave A, B, I and the stack unchanged.
- R9: Opcode 8 requests a backward search (`search_back_o`=1) and opcode 9 a forward one (`search_back_o`=0). `search_req_o` stays high and P holds until a cycle with `search_done_i`. In that cycle I takes `search_result_i` and P advances.
- R10: Opcode 10 pulses `alloc_req_o` with `alloc_size_o`=A and loads I from `alloc_addr_i` in the same cycle. Opcode 11 pulses `divide_o`.
- R11: P advances by one for every instruction retired or skipped, except when a pop or XOR writes P; in that case the next fetch is from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_addr_o | output | 16 | Address of the instruction byte (P) |
| fetch_data_i | input | 8 | Instruction byte at `fetch_addr_o`, same cycle |
| dmem_addr_o | output | 16 | Data address (I) |
| dmem_rdata_i | input | 16 | Byte at I in [15:8], byte at I+1 in [7:0] |
| dmem_we_o | output | 1 | Store strobe |
| dmem_wide_o | output | 1 | Store or load is a word |
| dmem_wdata_o | output | 16 | Store data |
| search_req_o | output | 1 | Label search request, held until done |
| search_back_o | output | 1 | Search direction, 1 = backward |
| search_done_i | input | 1 | Search finished this cycle |
| search_result_i | input | 16 | Address found by the search |
| alloc_req_o | output | 1 | Allocation request pulse |
| alloc_size_o | output | 16 | Requested size (A) |
| alloc_addr_i | input | 16 | Allocated address, same cycle |
| divide_o | output | 1 | Divide request pulse |
| illegal_o | output | 1 | Undefined opcode pulse |

## Verification
The hardest situation to reach is stack wrap-around combined with pops into P. Random code seldom runs 17 pushes in a row, and a random pop into P scatters execution. A directed program therefore pushes an incrementing A seventeen times, pops twice and stores each result. A second program computes an address, pushes it and pops it into P, which lands on a store with undefined opcodes placed in the gap. Constrained random code biased toward defined opcodes then runs long stretches against a bench model. That code mixes skip prefixes, searches with random completion delay and stores that rewrite the running program.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [3:0] {
    OP_NOP, OP_INC, OP_DEC, OP_SHL, OP_SKIP, OP_SRCH, OP_ALLOC, OP_DIV,
    OP_LDB, OP_STB, OP_LDW, OP_STW, OP_XOR, OP_PUSH, OP_POP, OP_BAD
  } op_e;

  localparam logic [1:0] RSEL_A = 2'd0;
  localparam logic [1:0] RSEL_B = 2'd1;
  localparam logic [1:0] RSEL_I = 2'd2;
  localparam logic [1:0] RSEL_P = 2'd3;
  localparam int NREGS = 4;

  typedef struct packed {
    op_e        op;
    logic [1:0] src;   // XOR source, push/pop register
    logic [1:0] dst;   // XOR destination
    logic       back;  // search direction
  } dec_t;
endpackage

// File: rtl/smc_decode.sv
module smc_decode
  import smc_pkg::*;
(
  input  logic [7:0] code_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o.src  = code_i[1:0];
    dec_o.dst  = code_i[3:2];
    dec_o.back = ~code_i[0];
    case (code_i) inside
      8'd0, 8'd1:      dec_o.op = OP_NOP;
      8'd2:            dec_o.op = OP_INC;
      8'd3:            dec_o.op = OP_DEC;
      8'd4:            dec_o.op = OP_SHL;
      8'd7:            dec_o.op = OP_SKIP;
      8'd8, 8'd9:      dec_o.op = OP_SRCH;
      8'd10:           dec_o.op = OP_ALLOC;
      8'd11:           dec_o.op = OP_DIV;
      8'd12:           dec_o.op = OP_LDB;
      8'd13:           dec_o.op = OP_STB;
      8'd14:           dec_o.op = OP_LDW;
      8'd15:           dec_o.op = OP_STW;
      [8'd16:8'd31]:   dec_o.op = OP_XOR;
      [8'd32:8'd35]:   dec_o.op = OP_PUSH;
      [8'd36:8'd39]:   dec_o.op = OP_POP;
      default:         dec_o.op = OP_BAD;
    endcase
  end
endmodule

// File: rtl/smc_stack.sv
module smc_stack #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] top_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] sp_q, sp_inc, sp_dec;
  logic [W-1:0]  ent_q [DEPTH];

  assign sp_inc = (sp_q == LAST) ? '0 : sp_q + 1'b1;
  assign sp_dec = (sp_q == '0) ? LAST : sp_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (push_i) sp_q <= sp_inc;
    else if (pop_i)  sp_q <= sp_dec;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             ent_q[k] <= '0;
      else if (push_i && sp_inc == AW'(k))     ent_q[k] <= wdata_i;
    end
  end

  assign top_o = ent_q[sp_q];

  AST_PUSH_ON_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(wdata_i)); // R5
  AST_PUSH_POP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i)); // R5
  AST_PUSH_POP_UNDO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(push_i) && pop_i |=> $stable(sp_q) || sp_q == $past(sp_q, 2)); // R5
endmodule

// File: rtl/smc_regfile.sv
module smc_regfile
  import smc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [1:0]             wr_sel_i,
  input  logic [W-1:0]           wr_data_i,
  input  logic                   pc_hold_i,
  output logic [NREGS-1:0][W-1:0] regs_o
);
  logic [W-1:0] regs_q [NREGS];

  for (genvar k = 0; k < NREGS; k++) begin : g_reg
    if (k == int'(RSEL_P)) begin : g_pc
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                regs_q[k] <= '0;
        else if (wr_en_i && wr_sel_i == 2'(k))      regs_q[k] <= wr_data_i;
        else if (!pc_hold_i)                        regs_q[k] <= regs_q[k] + 1'b1;
      end
    end else begin : g_gpr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                regs_q[k] <= '0;
        else if (wr_en_i && wr_sel_i == 2'(k))      regs_q[k] <= wr_data_i;
      end
    end
    assign regs_o[k] = regs_q[k];
  end

  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_hold_i |=> $stable(regs_o[RSEL_P])); // R9
endmodule

// File: rtl/smc_core.sv
module smc_core
  import smc_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] fetch_addr_o,
  input  logic [7:0]   fetch_data_i,
  output logic [W-1:0] dmem_addr_o,
  input  logic [W-1:0] dmem_rdata_i,
  output logic         dmem_we_o,
  output logic         dmem_wide_o,
  output logic [W-1:0] dmem_wdata_o,
  output logic         search_req_o,
  output logic         search_back_o,
  input  logic         search_done_i,
  input  logic [W-1:0] search_result_i,
  output logic         alloc_req_o,
  output logic [W-1:0] alloc_size_o,
  input  logic [W-1:0] alloc_addr_i,
  output logic         divide_o,
  output logic         illegal_o
);
  localparam int BW = 8;

  logic [7:0] op_byte;
  dec_t       dec;
  op_e        op;
  logic       search_q, back_q, skip_q;
  logic       live, srch_fire, pc_hold;
  logic [NREGS-1:0][W-1:0] regs;
  logic [W-1:0] a;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [W-1:0] wr_data;
  logic       push, pop;
  logic [W-1:0] stk_top;

  // upper opcode bits carry no meaning
  assign op_byte = fetch_data_i & 8'h3F;

  smc_decode u_dec (.code_i(op_byte), .dec_o(dec));

  assign op   = dec.op;
  assign a    = regs[RSEL_A];
  assign live = !search_q && !skip_q;

  assign search_req_o  = search_q || (live && op == OP_SRCH);
  assign search_back_o = search_q ? back_q : dec.back;
  assign srch_fire     = search_req_o && search_done_i;
  assign pc_hold       = search_req_o && !search_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      search_q <= 1'b0;
      back_q   <= 1'b0;
      skip_q   <= 1'b0;
    end else begin
      search_q <= pc_hold;
      back_q   <= search_back_o;
      skip_q   <= live && op == OP_SKIP && a != '0;
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_sel  = RSEL_A;
    wr_data = a;
    if (srch_fire) begin
      wr_en   = 1'b1;
      wr_sel  = RSEL_I;
      wr_data = search_result_i;
    end else if (live) begin
      case (op)
        OP_INC:   begin wr_en = 1'b1; wr_data = a + 1'b1; end
        OP_DEC:   begin wr_en = 1'b1; wr_data = a - 1'b1; end
        OP_SHL:   begin wr_en = 1'b1; wr_data = {a[W-2:0], 1'b0}; end
        OP_LDB:   begin wr_en = 1'b1; wr_data = {{(W-BW){1'b0}}, dmem_rdata_i[W-1 -: BW]}; end
        OP_LDW:   begin wr_en = 1'b1; wr_data = dmem_rdata_i; end
        OP_ALLOC: begin wr_en = 1'b1; wr_sel = RSEL_I; wr_data = alloc_addr_i; end
        OP_XOR:   begin wr_en = 1'b1; wr_sel = dec.dst; wr_data = regs[dec.src] ^ regs[dec.dst]; end
        OP_POP:   begin wr_en = 1'b1; wr_sel = dec.src; wr_data = stk_top; end
        default:  ;
      endcase
    end
  end

  smc_regfile #(.W(W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .pc_hold_i (pc_hold),
    .regs_o    (regs)
  );

  assign push = live && op == OP_PUSH;
  assign pop  = live && op == OP_POP;

  smc_stack #(.W(W), .DEPTH(DEPTH)) u_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (regs[dec.src]),
    .top_o   (stk_top)
  );

  assign fetch_addr_o = regs[RSEL_P];
  assign dmem_addr_o  = regs[RSEL_I];
  assign dmem_we_o    = live && (op == OP_STB || op == OP_STW);
  assign dmem_wide_o  = op == OP_STW || op == OP_LDW;
  assign dmem_wdata_o = (op == OP_STW) ? a : {a[BW-1:0], {(W-BW){1'b0}}};
  assign alloc_req_o  = live && op == OP_ALLOC;
  assign alloc_size_o = a;
  assign divide_o     = live && op == OP_DIV;
  assign illegal_o    = live && op == OP_BAD;

  AST_SKIP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_q |-> !(dmem_we_o || illegal_o || alloc_req_o || divide_o || search_req_o)); // R6
  AST_BAD_KEEPS_REGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(regs[RSEL_A]) && $stable(regs[RSEL_B]) && $stable(regs[RSEL_I])); // R8
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !search_req_o && !(live && ((op == OP_POP && dec.src == RSEL_P) ||
                                (op == OP_XOR && dec.dst == RSEL_P)))
    |=> fetch_addr_o == $past(fetch_addr_o) + 1'b1); // R11
  AST_SRCH_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_req_o && !search_done_i |=> search_req_o && search_back_o == $past(search_back_o)); // R9
  AST_SRCH_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_req_o && search_done_i |=> dmem_addr_o == $past(search_result_i)); // R9
  AST_ALLOC_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_req_o |=> dmem_addr_o == $past(alloc_addr_i)); // R10
  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dmem_we_o, alloc_req_o, divide_o, illegal_o})); // R8
endmodule

// File: tb/tb_smc_core.sv
`timescale 1ns/1ps
module tb_smc_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]  mem [1024];
  logic [15:0] fetch_addr, dmem_addr, dmem_wdata, alloc_size, dmem_rdata;
  logic [7:0]  fetch_data;
  logic        dmem_we, dmem_wide, search_req, search_back, alloc_req, divide, illegal;
  logic        search_done = 1'b0;
  logic [15:0] search_result = '0, alloc_addr = '0;
  logic [9:0]  lo_idx;

  assign fetch_data = mem[fetch_addr[9:0]];
  assign lo_idx     = dmem_addr[9:0] + 10'd1;
  assign dmem_rdata = {mem[dmem_addr[9:0]], mem[lo_idx]};

  smc_core dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_addr_o(fetch_addr), .fetch_data_i(fetch_data),
    .dmem_addr_o(dmem_addr), .dmem_rdata_i(dmem_rdata),
    .dmem_we_o(dmem_we), .dmem_wide_o(dmem_wide), .dmem_wdata_o(dmem_wdata),
    .search_req_o(search_req), .search_back_o(search_back),
    .search_done_i(search_done), .search_result_i(search_result),
    .alloc_req_o(alloc_req), .alloc_size_o(alloc_size), .alloc_addr_i(alloc_addr),
    .divide_o(divide), .illegal_o(illegal)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] mr [4];
  logic [15:0] mstk [16];
  int  msp;
  bit  mskip, msrch, mback;
  logic [15:0] log_wd [64];
  bit  log_wide [64];
  logic [15:0] log_addr [64];
  int  nlog, ill_cnt;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_bad(input logic [5:0] c);
    return c == 6'd5 || c == 6'd6 || c >= 6'd40;
  endfunction

  function automatic string cls_of(input logic [5:0] c);
    if (c <= 6'd4) return "R3";
    if (c == 6'd7) return "R6";
    if (c == 6'd8 || c == 6'd9) return "R9";
    if (c == 6'd10 || c == 6'd11) return "R10";
    if (c >= 6'd12 && c <= 6'd15) return "R7";
    if (c >= 6'd16 && c <= 6'd31) return "R4";
    if (c >= 6'd32 && c <= 6'd39) return "R5";
    return "R8";
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 4; k++) mr[k] = '0;
    for (int k = 0; k < 16; k++) mstk[k] = '0;
    msp = 0; mskip = 0; msrch = 0; mback = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    #1;
    chk(fetch_addr == 16'h0, "R1", "fetch address in reset", fetch_addr, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    nlog = 0; ill_cnt = 0;
  endtask

  task automatic do_cycle();
    logic [7:0]  b;
    logic [5:0]  c;
    logic [15:0] np, v, wd;
    logic [9:0]  ia;
    bit live, e_sreq, e_back, e_we, e_alloc, e_div, e_ill, done;
    bit cap_we, cap_wide;
    logic [15:0] cap_addr, cap_wd;
    string tag;
    @(negedge clk);
    done = ($urandom_range(0, 2) == 0);
    search_done   = done;
    search_result = 16'($urandom);
    alloc_addr    = 16'($urandom);
    #1;
    b = mem[mr[3][9:0]];
    c = b[5:0];
    live    = !msrch && !mskip;
    e_sreq  = msrch || (live && (c == 6'd8 || c == 6'd9));
    e_back  = msrch ? mback : (c == 6'd8);
    e_we    = live && (c == 6'd13 || c == 6'd15);
    e_alloc = live && c == 6'd10;
    e_div   = live && c == 6'd11;
    e_ill   = live && is_bad(c);
    tag = msrch ? "R9" : (mskip ? "R6" : cls_of(c));

    chk(fetch_addr == mr[3], {"R11 pc, op class ", tag}, "fetch_addr", fetch_addr, mr[3]);
    chk(search_req == e_sreq, "R9", {"search_req ", tag}, search_req, e_sreq);
    if (e_sreq) chk(search_back == e_back, "R9", "search_back", search_back, e_back);
    chk(illegal == e_ill, "R8", {"illegal ", tag}, illegal, e_ill);
    chk(dmem_we == e_we, "R7", {"dmem_we ", tag}, dmem_we, e_we);
    chk(alloc_req == e_alloc, "R10", {"alloc_req ", tag}, alloc_req, e_alloc);
    chk(divide == e_div, "R10", {"divide ", tag}, divide, e_div);
    if (e_alloc) chk(alloc_size == mr[0], "R10", "alloc_size", alloc_size, mr[0]);
    if (e_we) begin
      chk(dmem_addr == mr[2], "R7", "store addr", dmem_addr, mr[2]);
      chk(dmem_wide == (c == 6'd15), "R7", "store width", dmem_wide, c == 6'd15);
      if (c == 6'd15) chk(dmem_wdata == mr[0], "R7", "word data", dmem_wdata, mr[0]);
      else chk(dmem_wdata[15:8] == mr[0][7:0], "R7", "byte data", dmem_wdata[15:8], mr[0][7:0]);
    end

    cap_we = dmem_we; cap_wide = dmem_wide; cap_addr = dmem_addr; cap_wd = dmem_wdata;
    if (dmem_we && nlog < 64) begin
      log_wd[nlog] = dmem_wdata; log_wide[nlog] = dmem_wide; log_addr[nlog] = dmem_addr;
      nlog++;
    end
    if (illegal) ill_cnt++;

    // bench model of the next state
    ia = mr[2][9:0];
    np = mr[3] + 16'd1;
    if (e_sreq) begin
      mskip = 0;
      if (done) begin mr[2] = search_result; msrch = 0; end
      else begin msrch = 1; mback = e_back; np = mr[3]; end
    end else if (mskip) begin
      mskip = 0;
    end else begin
      case (c) inside
        6'd2: mr[0] = mr[0] + 16'd1;
        6'd3: mr[0] = mr[0] - 16'd1;
        6'd4: mr[0] = mr[0] << 1;
        6'd7: mskip = (mr[0] != 16'd0);
        6'd10: mr[2] = alloc_addr;
        6'd12: mr[0] = {8'h00, mem[ia]};
        6'd14: mr[0] = {mem[ia], mem[10'(ia + 10'd1)]};
        [6'd16:6'd31]: begin
          v = mr[c[1:0]] ^ mr[c[3:2]];
          if (c[3:2] == 2'd3) np = v; else mr[c[3:2]] = v;
        end
        [6'd32:6'd35]: begin
          msp = (msp + 1) % 16;
          mstk[msp] = mr[c[1:0]];
        end
        [6'd36:6'd39]: begin
          v = mstk[msp];
          msp = (msp + 15) % 16;
          if (c[1:0] == 2'd3) np = v; else mr[c[1:0]] = v;
        end
        default: ;
      endcase
    end
    mr[3] = np;

    @(posedge clk);
    #1;
    if (cap_we) begin
      wd = cap_wd;
      mem[cap_addr[9:0]] = wd[15:8];
      if (cap_wide) mem[10'(cap_addr[9:0] + 10'd1)] = wd[7:0];
    end
  endtask

  task automatic clear_mem();
    for (int k = 0; k < 1024; k++) mem[k] = 8'h00;
  endtask

  function automatic logic [7:0] gen_byte();
    int r, k;
    r = $urandom_range(0, 9);
    if (r < 7) begin
      k = $urandom_range(0, 37);
      k = (k < 5) ? k : k + 2;
      return {2'($urandom_range(0, 3)), 6'(k)};
    end
    return 8'($urandom);
  endfunction

  int seed_dummy;
  initial begin
    seed_dummy = $urandom(32'h5A17C0DE);
    clear_mem();

    // T1: reset zeros, upper bits ignored
    mem[0] = 8'h0D; mem[1] = 8'hC2; mem[2] = 8'h8D;
    do_reset();
    repeat (8) do_cycle();
    chk(nlog >= 2, "R1", "store count", nlog, 2);
    chk(log_addr[0] == 16'h0 && log_wd[0][15:8] == 8'h00, "R1", "first store zero", log_wd[0], 0);
    chk(log_wd[1][15:8] == 8'h01 && !log_wide[1], "R2", "C2 as inc, 8D as byte store", log_wd[1], 16'h0100);

    // T2: stack wrap after 17 pushes
    clear_mem();
    for (int k = 0; k < 17; k++) begin mem[2*k] = 8'h02; mem[2*k+1] = 8'h20; end
    mem[34] = 8'h24; mem[35] = 8'h0D; mem[36] = 8'h24; mem[37] = 8'h0D;
    do_reset();
    repeat (45) do_cycle();
    chk(log_wd[0][15:8] == 8'd17, "R5", "first pop after wrap", log_wd[0][15:8], 17);
    chk(log_wd[1][15:8] == 8'd16, "R5", "second pop after wrap", log_wd[1][15:8], 16);

    // T3: skip prefix
    clear_mem();
    mem[0] = 8'h07; mem[1] = 8'h02; mem[2] = 8'h07; mem[3] = 8'h02;
    mem[4] = 8'h07; mem[5] = 8'h05; mem[6] = 8'h0D;
    do_reset();
    repeat (10) do_cycle();
    chk(log_wd[0][15:8] == 8'd1, "R6", "A after taken and skipped inc", log_wd[0][15:8], 1);
    chk(ill_cnt == 0, "R6", "skipped illegal pulses", ill_cnt, 0);

    // T4: pop into P redirects past illegal bytes
    clear_mem();
    mem[0] = 8'h02;
    for (int k = 1; k < 5; k++) mem[k] = 8'h04;
    mem[5] = 8'h20; mem[6] = 8'h27;
    for (int k = 7; k < 16; k++) mem[k] = 8'h05;
    mem[16] = 8'h0D;
    do_reset();
    repeat (12) do_cycle();
    chk(ill_cnt == 0, "R11", "bytes jumped over", ill_cnt, 0);
    chk(nlog >= 1 && log_wd[0][15:8] == 8'd16, "R11", "store at jump target", log_wd[0][15:8], 16);

    // T5: big-endian word path and byte load
    clear_mem();
    mem[0] = 8'h02;
    for (int k = 1; k < 9; k++) mem[k] = 8'h04;
    mem[9] = 8'h18; mem[10] = 8'h0E; mem[11] = 8'h0F; mem[12] = 8'h0C; mem[13] = 8'h0F;
    mem[256] = 8'h12; mem[257] = 8'h34;
    do_reset();
    repeat (18) do_cycle();
    chk(log_wd[0] == 16'h1234 && log_wide[0], "R7", "word load/store", log_wd[0], 16'h1234);
    chk(log_addr[0] == 16'h0100, "R4", "XOR A into I", log_addr[0], 16'h0100);
    chk(log_wd[1] == 16'h0012 && log_wide[1], "R7", "byte load zero-extend", log_wd[1], 16'h0012);

    // T6: undefined opcodes
    clear_mem();
    mem[0] = 8'h05; mem[1] = 8'h3F; mem[2] = 8'h28; mem[3] = 8'h06; mem[4] = 8'h0D;
    do_reset();
    repeat (8) do_cycle();
    chk(ill_cnt == 4, "R8", "illegal pulse count", ill_cnt, 4);
    chk(log_wd[0][15:8] == 8'h00, "R8", "A untouched by illegal", log_wd[0][15:8], 0);

    // constrained random programs against the bench model
    for (int run = 0; run < 4; run++) begin
      for (int k = 0; k < 1024; k++) mem[k] = gen_byte();
      do_reset();
      repeat (10000) do_cycle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule